// File: doc/BRIEF.md
# Configurable LUT Memory Slice

A slice of four 64-bit storage cells, each of which serves either as a combinational lookup function or as a small piece of memory. Truth tables are loaded whole through a configuration port. From then on, the one storage array is read in a way set by a global mode.

In lookup mode, each cell returns the bit chosen by its own 6-bit address. In split mode, each cell acts as two 5-input functions that share the low address bits. The cells can also act together as a single 256x1 memory, writable or read-only, addressed by an 8-bit address whose top two bits pick the cell. Finally, each cell can act as a shift register of 16 or 32 stages, with the output tap chosen by its address.

Top module: `lut_mem_slice`

## Requirements
- R1: After reset, the mode is 6-input lookup and every storage bit is 0. As a result, `cell_o`, `cell_o5` and `mem_q` all read 0.
- R2: In 6-input lookup mode (code 0), `cell_o[i]` is the bit of cell i at the 6-bit address `cell_addr[6*i +: 6]`.
- R3: In split mode (code 1), `cell_o[i]` is bit `a[4:0]` of cell i and `cell_o5[i]` is bit `32 + a[4:0]`. Address bit 5 is ignored. In every other mode, `cell_o5` is 0.
- R4: In RAM mode (code 2), `wr_en` writes `wr_data` on the rising edge into bit `wr_addr[5:0]` of cell `wr_addr[7:6]`. Reads are asynchronous, so before that edge the old value is still visible.
- R5: In every mode, `mem_q` is bit `rd_addr[5:0]` of cell `rd_addr[7:6]`. Together the cells form one 256x1 array.
- R6: In ROM mode (code 3), `wr_en` has no effect, and the contents change only through the configuration port.
- R7: In 16-stage shift mode (code 4), each clock with `sh_en` high shifts `sh_in[i]` into bit 0 of cell i and moves bits 0..14 up by one. Bits 16..63 are left unchanged. The tap output is bit `a[3:0]`.
- R8: In 32-stage shift mode (code 5), each `sh_en` clock shifts bits 0..31 in the same way and leaves bits 32..63 unchanged. The tap output is bit `a[4:0]`.
- R9: `mode_in` is registered. A new mode takes effect one clock later, and a mode change never alters the stored contents.
- R10: A configuration load (`cfg_we`) to a cell takes precedence over a write or a shift to that same cell in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_in | input | 3 | Requested mode code |
| cfg_we | input | 1 | Load a whole truth table |
| cfg_cell | input | 2 | Cell selected for the load |
| cfg_data | input | 64 | Truth table contents |
| cell_addr | input | 24 | Per-cell 6-bit lookup address or tap |
| wr_en | input | 1 | RAM write enable |
| wr_addr | input | 8 | Combined write address |
| wr_data | input | 1 | RAM write bit |
| sh_en | input | 1 | Shift enable |
| sh_in | input | 4 | Per-cell shift input |
| rd_addr | input | 8 | Combined read address |
| cell_o | output | 4 | Per-cell lookup, RAM or tap output |
| cell_o5 | output | 4 | Per-cell upper-half output in split mode |
| mem_q | output | 1 | Combined 256x1 read output |

## Verification
The hardest case to reach from the ports is a shift mode that must leave the untouched upper part of each cell intact. No tap can show those bits. To check them, the bench first loads distinct truth tables, then shifts a known bit sequence for more cycles than there are stages. It then sweeps the whole 256-entry combined read address to expose every stored bit. Each mode switch is followed by the same sweep, which shows that the registered mode change preserved the contents.

// File: rtl/lut_mem_slice.sv
module lut_mem_slice #(
  parameter int NCELL  = 4,
  parameter int LUT_IN = 6,
  localparam int DEPTH = 1 << LUT_IN,
  localparam int SEL_W = $clog2(NCELL),
  localparam int MA_W  = LUT_IN + SEL_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                mode_in,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_cell,
  input  logic [DEPTH-1:0]          cfg_data,
  input  logic [NCELL*LUT_IN-1:0]   cell_addr,
  input  logic                      wr_en,
  input  logic [MA_W-1:0]           wr_addr,
  input  logic                      wr_data,
  input  logic                      sh_en,
  input  logic [NCELL-1:0]          sh_in,
  input  logic [MA_W-1:0]           rd_addr,
  output logic [NCELL-1:0]          cell_o,
  output logic [NCELL-1:0]          cell_o5,
  output logic                      mem_q
);
  localparam int SHORT = DEPTH / 4;
  localparam int LONG  = DEPTH / 2;

  typedef enum logic [2:0] {
    M_LUT6 = 3'd0, M_LUT5 = 3'd1, M_RAM = 3'd2,
    M_ROM  = 3'd3, M_SRL16 = 3'd4, M_SRL32 = 3'd5
  } mode_t;

  mode_t mode_q;
  logic [NCELL-1:0][DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_LUT6;
      cells  <= '0;
    end else begin
      mode_q <= mode_t'(mode_in);
      for (int i = 0; i < NCELL; i++) begin
        if (cfg_we && cfg_cell == SEL_W'(i))
          cells[i] <= cfg_data;
        else if (mode_q == M_RAM && wr_en && wr_addr[MA_W-1:LUT_IN] == SEL_W'(i))
          cells[i][wr_addr[LUT_IN-1:0]] <= wr_data;
        else if (sh_en && mode_q == M_SRL16)
          cells[i][SHORT-1:0] <= {cells[i][SHORT-2:0], sh_in[i]};
        else if (sh_en && mode_q == M_SRL32)
          cells[i][LONG-1:0] <= {cells[i][LONG-2:0], sh_in[i]};
      end
    end
  end

  assign mem_q = cells[rd_addr[MA_W-1:LUT_IN]][rd_addr[LUT_IN-1:0]];

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    logic [LUT_IN-1:0] a;
    assign a = cell_addr[g*LUT_IN +: LUT_IN];

    always_comb begin
      cell_o5[g] = 1'b0;
      case (mode_q)
        M_LUT5: begin
          cell_o[g]  = cells[g][{1'b0, a[LUT_IN-2:0]}];
          cell_o5[g] = cells[g][{1'b1, a[LUT_IN-2:0]}];
        end
        M_SRL16: cell_o[g] = cells[g][{2'b00, a[LUT_IN-3:0]}];
        M_SRL32: cell_o[g] = cells[g][{1'b0, a[LUT_IN-2:0]}];
        default: cell_o[g] = cells[g][a];
      endcase
    end

    // R7
    srl16_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_SRL16 && sh_en && !cfg_we) |=> $stable(cells[g][DEPTH-1:SHORT]));

    // R8
    srl32_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_SRL32 && sh_en && !cfg_we) |=> cells[g][0] == $past(sh_in[g]));

    // R5
    combined_read_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_LUT6 && rd_addr == {SEL_W'(g), a}) |-> mem_q == cell_o[g]);
  end

  // R4
  ram_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RAM && wr_en && !cfg_we) |=>
      cells[$past(wr_addr[MA_W-1:LUT_IN])][$past(wr_addr[LUT_IN-1:0])] == $past(wr_data));

  // R6
  rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ROM && !cfg_we) |=> $stable(cells));
endmodule

// File: tb/lut_mem_slice_bench.sv
module lut_mem_slice_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_we, wr_en, wr_data, sh_en, mem_q;
  logic [2:0] mode_in;
  logic [1:0] cfg_cell;
  logic [63:0] cfg_data;
  logic [23:0] cell_addr;
  logic [7:0] wr_addr, rd_addr;
  logic [3:0] sh_in, cell_o, cell_o5;

  lut_mem_slice u_lut_mem_slice (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .cfg_we(cfg_we),
    .cfg_cell(cfg_cell), .cfg_data(cfg_data), .cell_addr(cell_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sh_en(sh_en),
    .sh_in(sh_in), .rd_addr(rd_addr), .cell_o(cell_o), .cell_o5(cell_o5),
    .mem_q(mem_q)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] mdl [4];

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk); mode_in = m;
    @(negedge clk);
  endtask

  task automatic load(int c, logic [63:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_cell = c[1:0]; cfg_data = d;
    @(negedge clk); cfg_we = 1'b0; mdl[c] = d;
  endtask

  task automatic sweep(string r);
    for (int k = 0; k < 256; k++) begin
      rd_addr = k[7:0]; #1;
      chk(r, {63'd0, mem_q}, {63'd0, mdl[k/64][k%64]});
    end
  endtask

  task automatic t_reset;
    cell_addr = {4{6'd13}}; rd_addr = 8'd0; #1;
    chk("R1 cell_o", {60'd0, cell_o}, 64'd0);
    chk("R1 cell_o5", {60'd0, cell_o5}, 64'd0);
    for (int c = 0; c < 4; c++) mdl[c] = 64'd0;
    sweep("R1 contents");
  endtask

  task automatic t_lut6;
    load(0, 64'hF0E1_D2C3_B4A5_9687);
    load(1, 64'h0123_4567_89AB_CDEF);
    load(2, 64'h8000_0000_0000_0001);
    load(3, 64'h5A5A_3C3C_C3C3_A5A5);
    for (int a = 0; a < 64; a += 7) begin
      cell_addr = {4{a[5:0]}}; #1;
      for (int i = 0; i < 4; i++) chk("R2 lookup", {63'd0, cell_o[i]}, {63'd0, mdl[i][a]});
    end
    cell_addr = {4{6'd63}}; #1;
    for (int i = 0; i < 4; i++) chk("R2 top", {63'd0, cell_o[i]}, {63'd0, mdl[i][63]});
    sweep("R5 lut6");
  endtask

  task automatic t_lut5;
    set_mode(3'd1);
    for (int a = 0; a < 64; a += 9) begin
      cell_addr = {4{a[5:0]}}; #1;
      for (int i = 0; i < 4; i++) begin
        chk("R3 low half", {63'd0, cell_o[i]}, {63'd0, mdl[i][a%32]});
        chk("R3 high half", {63'd0, cell_o5[i]}, {63'd0, mdl[i][32 + a%32]});
      end
    end
  endtask

  task automatic t_ram;
    logic [7:0] addrs [4];
    addrs = '{8'h00, 8'h7F, 8'hBF, 8'hC5};
    set_mode(3'd2);
    for (int n = 0; n < 4; n++) begin
      logic [7:0] wa;
      logic nb;
      wa = addrs[n];
      nb = ~mdl[wa[7:6]][wa[5:0]];
      @(negedge clk); wr_en = 1'b1; wr_addr = wa; wr_data = nb; rd_addr = wa; #1;
      chk("R4 old before edge", {63'd0, mem_q}, {63'd0, ~nb});
      @(negedge clk); wr_en = 1'b0; mdl[wa[7:6]][wa[5:0]] = nb; #1;
      chk("R4 new after edge", {63'd0, mem_q}, {63'd0, nb});
      cell_addr = {4{wa[5:0]}}; #1;
      chk("R4 cell read", {63'd0, cell_o[wa[7:6]]}, {63'd0, nb});
    end
    chk("R3 o5 zero in ram", {60'd0, cell_o5}, 64'd0);
    sweep("R5 ram");
  endtask

  task automatic t_rom;
    set_mode(3'd3);
    @(negedge clk); wr_en = 1'b1; wr_addr = 8'h42; wr_data = ~mdl[1][2];
    @(negedge clk); wr_addr = 8'hC5; wr_data = ~mdl[3][5];
    @(negedge clk); wr_en = 1'b0;
    sweep("R6 rom ignores write");
    load(2, 64'h1357_9BDF_2468_ACE0);
    sweep("R6 rom cfg load");
  endtask

  task automatic t_shift(logic [2:0] m, int len, string r);
    set_mode(m);
    for (int n = 0; n < len + 5; n++) begin
      logic [3:0] v;
      v = 4'(n * 5 + 3) ^ 4'(n >> 1);
      @(negedge clk); sh_en = 1'b1; sh_in = v;
      for (int c = 0; c < 4; c++)
        for (int b = len - 1; b >= 0; b--)
          mdl[c][b] = (b == 0) ? v[c] : mdl[c][b-1];
    end
    @(negedge clk); sh_en = 1'b0;
    for (int t = 0; t < len; t++) begin
      cell_addr = {4{6'(t) | (len == 16 ? 6'b110000 : 6'b100000)}}; #1;
      for (int i = 0; i < 4; i++) chk({r, " tap"}, {63'd0, cell_o[i]}, {63'd0, mdl[i][t]});
    end
    chk({r, " o5 zero"}, {60'd0, cell_o5}, 64'd0);
    sweep({r, " contents"});
  endtask

  task automatic t_mode_switch;
    @(negedge clk); mode_in = 3'd1; cell_addr = {4{6'd35}}; #1;
    chk("R9 before edge", {60'd0, cell_o5}, 64'd0);
    @(negedge clk); #1;
    for (int i = 0; i < 4; i++) chk("R9 after edge", {63'd0, cell_o5[i]}, {63'd0, mdl[i][35]});
    sweep("R9 contents kept");
    set_mode(3'd0);
    sweep("R9 contents kept lut6");
  endtask

  task automatic t_prio;
    set_mode(3'd2);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cell = 2'd1; cfg_data = 64'hCAFE_F00D_0BAD_BEEE;
    wr_en = 1'b1; wr_addr = 8'h40; wr_data = 1'b1;
    @(negedge clk); cfg_we = 1'b0; wr_en = 1'b0; mdl[1] = 64'hCAFE_F00D_0BAD_BEEE;
    rd_addr = 8'h40; #1;
    chk("R10 cfg wins", {63'd0, mem_q}, 64'd0);
    set_mode(3'd4);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cell = 2'd2; cfg_data = 64'h0F0F_0F0F_0F0F_0F0F;
    sh_en = 1'b1; sh_in = 4'hF;
    for (int c = 0; c < 4; c++)
      if (c != 2)
        for (int b = 15; b >= 0; b--) mdl[c][b] = (b == 0) ? 1'b1 : mdl[c][b-1];
    mdl[2] = 64'h0F0F_0F0F_0F0F_0F0F;
    @(negedge clk); cfg_we = 1'b0; sh_en = 1'b0;
    sweep("R10 cfg over shift");
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_in = 3'd0; cfg_we = 1'b0; cfg_cell = 2'd0; cfg_data = 64'd0;
    cell_addr = 24'd0; wr_en = 1'b0; wr_addr = 8'd0; wr_data = 1'b0;
    sh_en = 1'b0; sh_in = 4'd0; rd_addr = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lut6();
    t_lut5();
    t_ram();
    t_rom();
    t_shift(3'd4, 16, "R7");
    t_shift(3'd5, 32, "R8");
    t_mode_switch();
    t_prio();
    report();
    $finish;
  end
endmodule